// File: doc/BRIEF.md
# Byte Align and Shuffle Unit

This block rearranges bytes of a 128-bit string formed from two 64-bit operands. Operand A supplies string bytes 0 to 7 and operand B supplies bytes 8 to 15. Byte 0 is the most significant byte of A, and the count runs down through each operand. Each input beat carries the two operands, a 64-bit graphics status word and an opcode.

The opcode chooses one of two operations:
- The align operation takes eight consecutive string bytes, starting at the byte offset held in the low three bits of the status word.
- The shuffle operation builds each of the eight output bytes from its own 4-bit index. The eight indices are packed into the upper half of the status word.

Writing the status word and decoding instructions are left to the surrounding logic.

Operands enter on a valid/ready stream and the result leaves on a second valid/ready stream, through a single registered stage.
- A beat is taken on a clock edge where `in_valid` and `in_ready` are both high.
- Its result appears with `out_valid` after that edge.
- A held result stays put while `out_ready` is low, and `in_ready` is then low.
- When the output is empty or is being drained in the same cycle, `in_ready` is high, so back-to-back beats flow at one per cycle.

Top module: `byte_permute_unit`

## Requirements
- R1: While reset is asserted and after its release, `out_valid` is 0 and `in_ready` is 1 until a beat is accepted.
- R2: With `op`=0 (align) and offset k = `status[2:0]`, `result` equals (`src_a` << 8k) | (`src_b` >> (64−8k)). Equivalently, output byte i (i=0 most significant) is string byte i+k.
- R3: With `op`=0 and offset 0, `result` equals `src_a` exactly, and no bit of `src_b` appears.
- R4: With `op`=1 (shuffle), output byte i (i=0 is bits [63:56]) is chosen by the index in `status[63-4i:60-4i]`. Byte 0 uses `status[63:60]` and byte 7 uses `status[35:32]`.
- R5: Shuffle index values 0–7 select byte 0–7 of `src_a`, and values 8–15 select byte 0–7 of `src_b`, counting from each operand's most significant byte.
- R6: Status bits outside the field of the chosen operation do not affect `result`. Align ignores `status[63:3]` and shuffle ignores `status[31:0]`.
- R7: A beat accepted on a clock edge produces exactly one output beat, valid from that edge. Without a new accepted beat, `out_valid` drops after the edge where it is taken.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `result` holds its value.
- R9: `in_ready` is 0 exactly when `out_valid`=1 and `out_ready`=0, so a full stage that is being drained still takes a new beat in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Input beat can be taken |
| op | input | 1 | 0 = align, 1 = shuffle |
| src_a | input | 64 | First operand, string bytes 0–7 |
| src_b | input | 64 | Second operand, string bytes 8–15 |
| status | input | 64 | Graphics status word: offset in [2:0], indices in [63:32] |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Downstream takes the result |
| result | output | 64 | Rearranged bytes |

## Verification
Each result is due one clock edge after the edge that accepts its beat, and there are no further registers in the path. The bench therefore drives a beat at a falling edge, lets the next rising edge take it, and compares `result` at the falling edge that follows. For the stall case, the bench holds `out_ready` low across several falling edges, checking `result`, `out_valid` and `in_ready` at each. It then releases `out_ready` and expects the queued beat's result at the falling edge after the release edge, with `out_valid` cleared one edge later.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  typedef enum logic {
    OP_ALIGN = 1'b0,
    OP_SHUF  = 1'b1
  } bpu_op_e;
endpackage

// File: rtl/bpu_align.sv
// Windowed byte extraction from the 2*LANES byte string.
// Packed index LANES*2-1 holds string byte 0 (most significant).
module bpu_align #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int STR_N = 2 * LANES,
  localparam int IDX_W = $clog2(STR_N),
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [STR_N-1:0][LANE_W-1:0] str,
  input  logic [OFF_W-1:0]             offset,
  output logic [LANES-1:0][LANE_W-1:0] res
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [IDX_W-1:0] pos;
    // string position of output byte i
    assign pos = IDX_W'(i) + IDX_W'(offset);
    assign res[LANES-1-i] = str[STR_N-1-int'(pos)];
  end
endmodule

// File: rtl/bpu_shuffle.sv
// Per-lane byte pick through a packed selector field.
module bpu_shuffle #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  localparam int STR_N = 2 * LANES,
  localparam int IDX_W = $clog2(STR_N),
  localparam int SEL_W = LANES * IDX_W
) (
  input  logic [STR_N-1:0][LANE_W-1:0] str,
  input  logic [SEL_W-1:0]             sel,
  output logic [LANES-1:0][LANE_W-1:0] res
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [IDX_W-1:0] idx;
    // output byte 0 takes the top index nibble
    assign idx = sel[(LANES-1-i)*IDX_W +: IDX_W];
    assign res[LANES-1-i] = str[STR_N-1-int'(idx)];
  end
endmodule

// File: rtl/bpu_out_stage.sv
// Single registered stage with valid/ready on both sides.
module bpu_out_stage #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         full_q;
  logic [W-1:0] data_q;
  logic         take;

  assign up_ready = !full_q || dn_ready;
  assign take     = up_valid && up_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (take) begin
        full_q <= 1'b1;
        data_q <= up_data;
      end else if (dn_ready) begin
        full_q <= 1'b0;
      end
    end
  end

  assign dn_valid = full_q;
  assign dn_data  = data_q;
endmodule

// File: rtl/byte_permute_unit.sv
module byte_permute_unit #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  parameter int CTRL_W = 64,
  localparam int DATA_W  = LANES * LANE_W,
  localparam int STR_N   = 2 * LANES,
  localparam int IDX_W   = $clog2(STR_N),
  localparam int OFF_W   = $clog2(LANES),
  localparam int SEL_W   = LANES * IDX_W,
  localparam int SEL_LSB = CTRL_W - SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              op,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  input  logic [CTRL_W-1:0] status,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] result
);
  import bpu_pkg::*;

  logic [STR_N-1:0][LANE_W-1:0] str;
  logic [LANES-1:0][LANE_W-1:0] align_res;
  logic [LANES-1:0][LANE_W-1:0] shuf_res;
  logic [DATA_W-1:0]            next_res;
  bpu_op_e                      op_e;
  logic                         unused_status_mid;

  assign str               = {src_a, src_b};
  assign op_e              = bpu_op_e'(op);
  assign unused_status_mid = ^status[SEL_LSB-1:OFF_W];

  bpu_align #(.LANES(LANES), .LANE_W(LANE_W)) u_align (
    .str    (str),
    .offset (status[OFF_W-1:0]),
    .res    (align_res)
  );

  bpu_shuffle #(.LANES(LANES), .LANE_W(LANE_W)) u_shuffle (
    .str (str),
    .sel (status[CTRL_W-1:SEL_LSB]),
    .res (shuf_res)
  );

  always_comb begin
    unique case (op_e)
      OP_SHUF: next_res = shuf_res;
      default: next_res = align_res;
    endcase
  end

  bpu_out_stage #(.W(DATA_W)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (next_res),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (result)
  );
endmodule

// File: rtl/bpu_checker.sv
module bpu_checker #(
  parameter int DATA_W = 64,
  parameter int CTRL_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              op,
  input logic [DATA_W-1:0] src_a,
  input logic [CTRL_W-1:0] status,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] result
);
  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> !out_valid);

  p_zero_offset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !op && status[2:0] == 3'd0) |=> (result == $past(src_a)));

  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(result)));

  p_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  p_empty_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid || out_ready) |-> in_ready);
endmodule

bind byte_permute_unit bpu_checker #(.DATA_W(DATA_W), .CTRL_W(CTRL_W)) u_bpu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .op        (op),
  .src_a     (src_a),
  .status    (status),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .result    (result)
);

// File: tb/sim_byte_permute_unit.sv
module sim_byte_permute_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        op = 1'b0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [63:0] status = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] result;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  byte_permute_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .src_a(src_a), .src_b(src_b), .status(status),
    .out_valid(out_valid), .out_ready(out_ready), .result(result)
  );

  function automatic logic [63:0] ref_align(logic [63:0] a, logic [63:0] b, logic [2:0] k);
    logic [63:0] r;
    r = a << (8 * k);
    if (k != 3'd0) r = r | (b >> (64 - 8 * k));
    return r;
  endfunction

  function automatic logic [63:0] ref_shuffle(logic [63:0] a, logic [63:0] b, logic [63:0] s);
    logic [7:0] bytes [16];
    logic [63:0] r;
    for (int k = 0; k < 8; k++) begin
      bytes[k]     = a[63 - 8*k -: 8];
      bytes[k + 8] = b[63 - 8*k -: 8];
    end
    r = '0;
    for (int i = 0; i < 8; i++) r[63 - 8*i -: 8] = bytes[s[63 - 4*i -: 4]];
    return r;
  endfunction

  task automatic check(input logic [63:0] got, input logic [63:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // Drive at a falling edge, accept at the rising edge, check at the next falling edge.
  task automatic beat(input logic o, input logic [63:0] a, input logic [63:0] b,
                      input logic [63:0] s, input logic [63:0] exp, input string req);
    op = o; src_a = a; src_b = b; status = s; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({63'd0, out_valid}, 64'd1, "R7");
    check(result, exp, req);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog got=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [63:0] pa [4];
    logic [63:0] sa;
    logic [63:0] a1, b1, s1, a2, b2, s2;
    pa[0] = 64'h0011223344556677;
    pa[1] = 64'h8899AABBCCDDEEFF;
    pa[2] = 64'hFFFFFFFFFFFFFFFF;
    pa[3] = 64'h0123456789ABCDEF;

    repeat (3) @(negedge clk);
    // R1: empty stage during reset
    check({63'd0, out_valid}, 64'd0, "R1");
    check({63'd0, in_ready}, 64'd1, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check({63'd0, out_valid}, 64'd0, "R1");

    // R2 / R3: every offset over several operand pairs, upper status bits randomised (R6)
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 8; k++) begin
        logic [63:0] b;
        b = pa[(p + 1) % 4] ^ 64'h5A5A_0000_A5A5_0000;
        sa = {rnd64()} & ~64'h7 | 64'(k);
        beat(1'b0, pa[p], b, sa, ref_align(pa[p], b, 3'(k)), k == 0 ? "R3" : "R2");
      end
    end
    // R3: zero offset with all-ones src_b
    beat(1'b0, 64'hDEADBEEF00C0FFEE, '1, 64'hFFFF_FFFF_FFFF_FFF8, 64'hDEADBEEF00C0FFEE, "R3");

    // R4 / R5: every lane set to one index, each index value 0..15
    for (int v = 0; v < 16; v++) begin
      logic [63:0] s;
      s = {8{4'(v)}} << 32 | 64'(rnd64() & 64'hFFFF_FFFF);
      beat(1'b1, pa[3], pa[1], s, ref_shuffle(pa[3], pa[1], s), v < 8 ? "R5" : "R5");
    end
    // R4: identity and reversal patterns
    beat(1'b1, pa[3], pa[0], 64'h01234567_00000000, pa[3], "R4");
    beat(1'b1, pa[3], pa[0], 64'hFEDCBA98_00000000, 64'h7766554433221100, "R4");
    // R6: shuffle ignores status[31:0]
    beat(1'b1, pa[3], pa[0], 64'h89ABCDEF_FFFFFFFF, pa[0], "R6");
    // R4: random operands and selectors
    for (int r = 0; r < 40; r++) begin
      logic [63:0] a, b, s;
      a = rnd64(); b = rnd64(); s = rnd64();
      beat(1'b1, a, b, s, ref_shuffle(a, b, s), "R4");
    end

    // R8 / R9: stall then drain
    @(negedge clk);
    a1 = rnd64(); b1 = rnd64(); s1 = rnd64();
    a2 = rnd64(); b2 = rnd64(); s2 = rnd64();
    out_ready = 1'b0;
    beat(1'b0, a1, b1, s1, ref_align(a1, b1, s1[2:0]), "R2");
    op = 1'b1; src_a = a2; src_b = b2; status = s2; in_valid = 1'b1;
    for (int c = 0; c < 3; c++) begin
      check({63'd0, in_ready}, 64'd0, "R9");
      check({63'd0, out_valid}, 64'd1, "R8");
      check(result, ref_align(a1, b1, s1[2:0]), "R8");
      @(negedge clk);
    end
    out_ready = 1'b1;
    #1;
    check({63'd0, in_ready}, 64'd1, "R9");
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({63'd0, out_valid}, 64'd1, "R7");
    check(result, ref_shuffle(a2, b2, s2), "R4");
    @(negedge clk);
    check({63'd0, out_valid}, 64'd0, "R7");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule